// File: doc/BRIEF.md
# Six-Channel PWM Generator with Complementary Dead-Time Pair

This block produces six pulse-width-modulated outputs from one shared period counter. Software sets one period value that all channels share and a separate duty value for each channel. A channel output is high while the counter is below that channel's duty. The counter advances only on ticks from one of several clock-enable sources, picked by a select code. Channel 0 does not drive a single output. It drives a complementary pair, and a programmable non-overlap gap of 0 to 15 ticks is placed on both of its edges. Each of channels 1 to 5 drives one output.

Period and duty writes go into holding registers. The running values take them over only when the counter wraps, so a period in progress is never cut short or stretched. While the block is disabled, the running values follow the holding registers at once. Each wrap sets an interrupt flag, which stays set until a clear pulse removes it.

Top module: `mpwm_dt`

## Requirements
- R1: While `en` is low, the counter stays at 0, every PWM output is low, and the running period and duty values follow the holding registers. All outputs and `irq` are low after reset.
- R2: While enabled, the counter steps by one on each selected tick from 0 up to the running period P, then returns to 0. One period lasts P+1 ticks.
- R3: `src_sel` value k selects `src_tick[k]` as the counter tick (0 system, 1 fast/256, 2 fast, 3 fast x2). Pulses on the other source inputs have no effect on the period.
- R4: A channel output is high for the counter values below its duty D. When a tick arrives every clock, a channel is high for D clocks of each P+1. D = 0 gives a constant low, and D > P gives a constant high.
- R5: A write to the period or to a duty changes nothing in the period in progress. The new value takes effect from the next wrap.
- R6: Channel 0 drives `out_p` with the level of its compare and `out_n` with the inverse of that level. The two outputs are never high at the same time.
- R7: With gap G on `dt_len`, each output of the pair goes high only after its compare level has been stable for G ticks. With a tick every clock, for 1 ≤ D ≤ P, `out_p` is high for max(0, D−G) clocks and `out_n` is high for max(0, P+1−D−G) clocks per period.
- R8: `irq` goes high at each counter wrap and stays high until a one-cycle `irq_clr` pulse clears it. If a wrap and a clear arrive in the same cycle, the wrap wins.
- R9: A duty write with a channel number of 6 or higher changes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable |
| src_sel | input | 2 | Tick source select |
| src_tick | input | 4 | Tick enables, one per source |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period value P |
| duty_wr | input | 1 | Duty write strobe |
| duty_ch | input | 3 | Channel number for the duty write |
| duty_wdata | input | 16 | Duty value |
| dt_len | input | 4 | Non-overlap gap in ticks |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| out_p | output | 1 | Channel 0 positive output |
| out_n | output | 1 | Channel 0 complementary output |
| out_ch | output | 5 | Outputs of channels 1 to 5 (bit i is channel i) |
| irq | output | 1 | Period-wrap interrupt flag |

## Verification
A wrong counter or period value shows up as a wrong spacing between interrupt edges within one period. A wrong running duty shows up as a wrong high count on that channel in the first full period after a wrap. A load at the wrong moment is exposed when a value written in the middle of a period changes that same period rather than the next one. A dead-time counter in the wrong state shifts the high counts of the pair by the error in ticks, or turns both outputs on together. The overlap is flagged on the clock edge where it happens.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
   typedef enum logic [1:0] {
      SRC_SYS   = 2'd0,
      SRC_FDIV  = 2'd1,
      SRC_FAST  = 2'd2,
      SRC_FASTX = 2'd3
   } mpwm_src_e;

   localparam int unsigned MPWM_MAX_DT_BITS = 8;
endpackage

// File: rtl/mpwm_ticksel.sv
module mpwm_ticksel #(
   parameter int unsigned NSRC = 4,
   localparam int unsigned SELW = $clog2(NSRC)
) (
   input  logic [NSRC-1:0] src_tick,
   input  logic [SELW-1:0] sel,
   output logic            tick
);
   generate
      if (NSRC == (1 << SELW)) begin : g_full
         assign tick = src_tick[sel];
      end else begin : g_part
         always_comb begin
            tick = 1'b0;
            for (int i = 0; i < NSRC; i++) begin
               if (sel == SELW'(i)) tick = src_tick[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mpwm_timebase.sv
module mpwm_timebase #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          per_wr,
   input  logic [CW-1:0] per_wdata,
   input  logic          irq_clr,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] per_act,
   output logic          load,
   output logic          irq
);
   logic [CW-1:0] per_sh_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] per_q;
   logic          irq_q;
   logic          wrap;

   assign wrap = run && tick && (cnt_q >= per_q);
   assign load = wrap || !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_sh_q <= '0;
         cnt_q    <= '0;
         per_q    <= '0;
         irq_q    <= 1'b0;
      end else begin
         if (per_wr) per_sh_q <= per_wdata;
         if (load) begin
            cnt_q <= '0;
            per_q <= per_sh_q;
         end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
         end
         irq_q <= (irq_q && !irq_clr) || wrap;
      end
   end

   assign cnt     = cnt_q;
   assign per_act = per_q;
   assign irq     = irq_q;
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan #(
   parameter int unsigned CW  = 16,
   parameter int unsigned CHW = 3,
   parameter int unsigned IDX = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           load,
   input  logic           duty_wr,
   input  logic [CHW-1:0] duty_ch,
   input  logic [CW-1:0]  duty_wdata,
   input  logic [CW-1:0]  cnt,
   output logic           lvl
);
   logic [CW-1:0] duty_sh_q;
   logic [CW-1:0] duty_q;
   logic          lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_sh_q <= '0;
         duty_q    <= '0;
         lvl_q     <= 1'b0;
      end else begin
         if (duty_wr && duty_ch == CHW'(IDX)) duty_sh_q <= duty_wdata;
         if (load) duty_q <= duty_sh_q;
         lvl_q <= run && (cnt < duty_q);
      end
   end

   assign lvl = lvl_q;
endmodule

// File: rtl/mpwm_deadband.sv
module mpwm_deadband #(
   parameter int unsigned DTW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           on,
   input  logic           tick,
   input  logic [DTW-1:0] dt,
   input  logic           lvl,
   output logic           p,
   output logic           n
);
   logic           prev_q;
   logic [DTW-1:0] dcnt_q;
   logic           changed;
   logic           settled;

   assign changed = lvl != prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         dcnt_q <= '0;
      end else begin
         prev_q <= lvl;
         if (changed)                   dcnt_q <= tick ? DTW'(1) : '0;
         else if (tick && dcnt_q < dt)  dcnt_q <= dcnt_q + DTW'(1);
      end
   end

   assign settled = (dt == '0) || (!changed && dcnt_q >= dt);
   assign p = on &&  lvl && settled;
   assign n = on && !lvl && settled;
endmodule

// File: rtl/mpwm_dt.sv
module mpwm_dt #(
   parameter int unsigned NCH  = 6,
   parameter int unsigned CW   = 16,
   parameter int unsigned DTW  = 4,
   parameter int unsigned NSRC = 4,
   localparam int unsigned CHW  = $clog2(NCH),
   localparam int unsigned SELW = $clog2(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [SELW-1:0] src_sel,
   input  logic [NSRC-1:0] src_tick,
   input  logic            per_wr,
   input  logic [CW-1:0]   per_wdata,
   input  logic            duty_wr,
   input  logic [CHW-1:0]  duty_ch,
   input  logic [CW-1:0]   duty_wdata,
   input  logic [DTW-1:0]  dt_len,
   input  logic            irq_clr,
   output logic            out_p,
   output logic            out_n,
   output logic [NCH-1:1]  out_ch,
   output logic            irq
);
   generate
      if (NCH < 2 || NCH > 64) begin : g_bad_nch
         $error("mpwm_dt: NCH must be 2..64");
      end
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("mpwm_dt: CW must be 2..32");
      end
      if (DTW < 1 || DTW > mpwm_pkg::MPWM_MAX_DT_BITS) begin : g_bad_dtw
         $error("mpwm_dt: DTW out of range");
      end
      if (NSRC < 2) begin : g_bad_nsrc
         $error("mpwm_dt: NSRC must be at least 2");
      end
   endgenerate

   logic           tick_w;
   logic [CW-1:0]  cnt_w;
   logic [CW-1:0]  per_w;
   logic           load_w;
   logic [NCH-1:0] lvl_w;
   logic           on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) on_q <= 1'b0;
      else        on_q <= en;
   end

   mpwm_ticksel #(.NSRC(NSRC)) u_sel (
      .src_tick (src_tick),
      .sel      (src_sel),
      .tick     (tick_w)
   );

   mpwm_timebase #(.CW(CW)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (en),
      .tick      (tick_w),
      .per_wr    (per_wr),
      .per_wdata (per_wdata),
      .irq_clr   (irq_clr),
      .cnt       (cnt_w),
      .per_act   (per_w),
      .load      (load_w),
      .irq       (irq)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         mpwm_chan #(.CW(CW), .CHW(CHW), .IDX(i)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (en),
            .load       (load_w),
            .duty_wr    (duty_wr),
            .duty_ch    (duty_ch),
            .duty_wdata (duty_wdata),
            .cnt        (cnt_w),
            .lvl        (lvl_w[i])
         );
      end
      for (genvar j = 1; j < NCH; j++) begin : g_out
         assign out_ch[j] = lvl_w[j];
      end
   endgenerate

   mpwm_deadband #(.DTW(DTW)) u_db (
      .clk   (clk),
      .rst_n (rst_n),
      .on    (on_q),
      .tick  (tick_w),
      .dt    (dt_len),
      .lvl   (lvl_w[0]),
      .p     (out_p),
      .n     (out_n)
   );
endmodule

// File: rtl/mpwm_dt_chk.sv
module mpwm_dt_chk #(
   parameter int unsigned NCH = 6,
   parameter int unsigned CW  = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           en,
   input logic           tick,
   input logic [CW-1:0]  cnt,
   input logic [CW-1:0]  per_act,
   input logic           irq,
   input logic           irq_clr,
   input logic [NCH-1:1] out_ch,
   input logic           out_p,
   input logic           out_n
);
   p_pair_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_p && out_n));

   p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (out_ch == '0 && !out_p && !out_n));

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per_act);

   p_nosel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(cnt));

   p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !tick) |=> !irq);
endmodule

bind mpwm_dt mpwm_dt_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .tick    (tick_w),
   .cnt     (cnt_w),
   .per_act (per_w),
   .irq     (irq),
   .irq_clr (irq_clr),
   .out_ch  (out_ch),
   .out_p   (out_p),
   .out_n   (out_n)
);

// File: tb/mpwm_dt_tb.sv
module mpwm_dt_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [1:0]  src_sel = 2'd0;
   logic [3:0]  src_tick = 4'hF;
   logic        per_wr = 1'b0;
   logic [15:0] per_wdata = '0;
   logic        duty_wr = 1'b0;
   logic [2:0]  duty_ch = '0;
   logic [15:0] duty_wdata = '0;
   logic [3:0]  dt_len = '0;
   logic        irq_clr = 1'b0;
   logic        out_p, out_n, irq;
   logic [5:1]  out_ch;

   int checks = 0;
   int errors = 0;
   int tmode = -1;
   int ph = 0;
   int hi[6];
   int pc, nc;

   always #(CLK_PERIOD/2) clk = ~clk;

   mpwm_dt u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel), .src_tick(src_tick),
      .per_wr(per_wr), .per_wdata(per_wdata), .duty_wr(duty_wr), .duty_ch(duty_ch),
      .duty_wdata(duty_wdata), .dt_len(dt_len), .irq_clr(irq_clr),
      .out_p(out_p), .out_n(out_n), .out_ch(out_ch), .irq(irq)
   );

   // tick generator: all ones, or selected source every third clock with noise on others
   always @(negedge clk) begin
      if (tmode < 0) begin
         src_tick <= 4'hF;
      end else begin
         ph = (ph == 2) ? 0 : ph + 1;
         for (int s = 0; s < 4; s++)
            src_tick[s] <= (s == tmode) ? (ph == 0) : 1'($urandom);
      end
   end

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_ch(int d, int p);
      if (d == 0) return 0;
      if (d > p)  return p + 1;
      return d;
   endfunction
   function automatic int exp_p(int d, int p, int g);
      if (d == 0) return 0;
      if (d > p)  return p + 1;
      return (d > g) ? d - g : 0;
   endfunction
   function automatic int exp_n(int d, int p, int g);
      if (d == 0) return p + 1;
      if (d > p)  return 0;
      return (p + 1 - d > g) ? p + 1 - d - g : 0;
   endfunction

   task automatic wr_per(input int v);
      per_wdata = 16'(v); per_wr = 1'b1;
      @(negedge clk); per_wr = 1'b0;
   endtask
   task automatic wr_duty(input int ch, input int v);
      duty_ch = 3'(ch); duty_wdata = 16'(v); duty_wr = 1'b1;
      @(negedge clk); duty_wr = 1'b0;
   endtask

   task automatic configure(input int p, input int d[6], input int g);
      en = 1'b0;
      @(negedge clk);
      wr_per(p);
      for (int c = 0; c < 6; c++) wr_duty(c, d[c]);
      dt_len = 4'(g);
      irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
      @(negedge clk);
      en = 1'b1;
   endtask

   task automatic wait_irq();
      while (!irq) @(negedge clk);
   endtask

   // counts high samples over one wrap-aligned period of p+1 clocks
   task automatic measure(input int p);
      wait_irq();
      irq_clr = 1'b1;
      for (int c = 0; c < 6; c++) hi[c] = 0;
      pc = 0; nc = 0;
      for (int k = 1; k <= p + 1; k++) begin
         @(negedge clk);
         irq_clr = 1'b0;
         for (int c = 1; c < 6; c++) if (out_ch[c]) hi[c]++;
         if (out_p) pc++;
         if (out_n) nc++;
      end
   endtask

   // clocks between two wraps; optionally writes a new period mid-way
   task automatic gap(output int clocks, input bit do_wr, input int newp);
      wait_irq();
      irq_clr = 1'b1;
      clocks = 0;
      do begin
         @(negedge clk);
         irq_clr = 1'b0;
         per_wr = 1'b0;
         clocks++;
         if (do_wr && clocks == 2) begin per_wdata = 16'(newp); per_wr = 1'b1; end
      end while (!irq && clocks < 5000);
      per_wr = 1'b0;
   endtask

   task automatic check_all(input int p, input int d[6], input int g, input string tag);
      for (int c = 1; c < 6; c++) chk(hi[c], exp_ch(d[c], p), {tag, " R4 ch"});
      chk(pc, exp_p(d[0], p, g), {tag, " R7 out_p"});
      chk(nc, exp_n(d[0], p, g), {tag, " R7 out_n"});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int d[6];
      int p, g, cl;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({out_ch, out_p, out_n}, 0, "R1 outputs after reset");
      chk(irq, 0, "R1 irq after reset");

      // R4/R6/R7 directed: duty 0 and duty above period, no gap
      d = '{0, 1, 9, 10, 11, 40};
      configure(9, d, 0);
      measure(9); measure(9);
      check_all(9, d, 0, "dir-edge");
      d = '{12, 0, 3, 5, 7, 2};
      configure(9, d, 0);
      measure(9); measure(9);
      check_all(9, d, 0, "dir-high");
      // R7 gap longer than both pulse halves
      d = '{4, 1, 2, 3, 4, 5};
      configure(9, d, 15);
      measure(9); measure(9);
      check_all(9, d, 15, "dir-gap15");
      chk(pc + nc, 0, "R6 pair idle when gap exceeds pulse");
      // R1 disabled outputs
      en = 1'b0;
      repeat (3) @(negedge clk);
      chk({out_ch, out_p, out_n}, 0, "R1 outputs while disabled");

      // R5 duty write mid-period
      d = '{5, 3, 3, 3, 3, 3};
      configure(9, d, 0);
      measure(9);
      wait_irq();
      irq_clr = 1'b1;
      for (int c = 0; c < 6; c++) hi[c] = 0;
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         irq_clr = 1'b0;
         duty_wr = 1'b0;
         if (k == 3) begin duty_ch = 3'd1; duty_wdata = 16'd7; duty_wr = 1'b1; end
         if (out_ch[1]) hi[1]++;
      end
      duty_wr = 1'b0;
      chk(hi[1], 3, "R5 duty unchanged in current period");
      measure(9);
      chk(hi[1], 7, "R5 duty applied after wrap");

      // R9 out-of-range channel numbers
      wr_duty(6, 0);
      wr_duty(7, 0);
      measure(9); measure(9);
      d = '{5, 7, 3, 3, 3, 3};
      check_all(9, d, 0, "R9 ignored ch6/ch7");

      // R5/R2 period write mid-period
      gap(cl, 1'b0, 0);
      gap(cl, 1'b1, 5);
      chk(cl, 10, "R5 period unchanged in current period");
      gap(cl, 1'b0, 0);
      chk(cl, 6, "R2 period P+1 after new period");

      // R3 source select with noise on the others
      for (int s = 0; s < 4; s++) begin
         d = '{1, 1, 1, 1, 1, 1};
         tmode = s;
         src_sel = 2'(s);
         configure(4, d, 0);
         gap(cl, 1'b0, 0);
         gap(cl, 1'b0, 0);
         chk(cl, 15, "R3 period spacing on selected source");
      end
      tmode = -1;
      src_sel = 2'd0;

      // R8 hold and clear
      d = '{1, 1, 1, 1, 1, 1};
      configure(20, d, 0);
      wait_irq();
      repeat (45) @(negedge clk);
      chk(irq, 1, "R8 irq held without clear");
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk(irq, 0, "R8 irq cleared by pulse");

      // random configurations
      for (int t = 0; t < 24; t++) begin
         p = 3 + int'($urandom % 30);
         g = int'($urandom % 16);
         for (int c = 0; c < 6; c++) d[c] = int'($urandom % (p + 3));
         configure(p, d, g);
         measure(p); measure(p);
         check_all(p, d, g, "rand");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule